// File: doc/BRIEF.md
# Signed-Digit Radix-10 Multiplier Recoder

This block turns a packed BCD multiplier operand into a string of signed radix-10 digits in the range -5 to +5. A partial-product multiplexer can use this form directly. A row needs only the multiples 1X to 5X of the multiplicand, plus a sign, and never 6X to 9X. For each digit position the block emits a 6-bit select code. Five one-hot lines choose the magnitude, and one line marks a negative value. The output holds one more position than the input has digits.

The work is local to each position. A digit borrows a transfer of one from the position below only when that lower BCD digit is 5 or more. Nothing ripples across the word, so the logic depth does not grow with the operand width. The combinational recoding drives a register stage, and that register is the block's output.

Top module: `sd10_recoder`

## Requirements
- R1: While `rst` is high at a rising clock edge, every bit of `sel_out` is cleared to 0 after that edge.
- R2: `sel_out` shows the recoding of the `bcd_in` value sampled at the previous rising edge, and it does not change between edges.
- R3: Each position `i` occupies `sel_out[6*i+5 : 6*i]`. Bit `6*i+k` for k = 0..4 selects magnitude k+1, and bit `6*i+5` set means negative. At most one magnitude line is high, and a zero magnitude drives all five low.
- R4: The transfer into position `i` (1 ≤ i ≤ DIGITS) is 1 exactly when BCD digit `i-1` (`bcd_in[4*i-1 : 4*i-4]`) is 5 or more. The transfer into position 0 is 0.
- R5: A digit Y below 5 with no incoming transfer recodes to +Y, with the sign bit clear.
- R6: A digit Y below 5 with an incoming transfer recodes to +(Y+1), so 4 becomes +5.
- R7: A digit Y of 5 or more with no incoming transfer recodes to -(10-Y), so 6 becomes -4 and 5 becomes -5.
- R8: A digit Y of 5 or more with an incoming transfer recodes to -(9-Y), with the sign bit set. A 9 therefore becomes code 6'b100000, which has zero magnitude and the sign set.
- R9: Extra position DIGITS is always positive. It is +1 when the top BCD digit is 5 or more, and 0 otherwise.
- R10: The sum over all positions of value(i)·10^i equals the binary value of the BCD input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bcd_in | input | 4*DIGITS | Packed BCD multiplier, digit 0 in bits [3:0] |
| sel_out | output | 6*(DIGITS+1) | Registered signed-digit select codes, 6 bits per position |

## Verification
The assertions take it as given that every 4-bit group of `bcd_in` is a legal BCD digit from 0 to 9. One property flags any pattern from 10 to 15, and the recoding of such patterns is not defined. The stimulus builds every operand one digit at a time from values 0 to 9. It sweeps a single non-zero digit at each position, every value pair at each pair of adjacent positions, the all-fours, all-fives and all-nines words, and random digit strings. This covers every transfer case, including the case where a 9 meets an incoming transfer.

// File: rtl/sd10_pkg.sv
package sd10_pkg;

    localparam int DIGIT_W = 4;
    localparam int MAG_W   = 5;
    localparam int CODE_W  = MAG_W + 1;

    typedef logic [DIGIT_W-1:0] bcd_digit_t;

    // One recoded position: sign on top, one-hot magnitude below
    typedef struct packed {
        logic             neg;
        logic [MAG_W-1:0] mag_sel;
    } sd_code_t;

    // A digit of five or more hands a transfer to the next position up
    function automatic logic digit_is_high(input bcd_digit_t y);
        return (y >= 4'd5);
    endfunction

    // Magnitude 0..5 to one-hot select lines (bit k means k+1)
    function automatic logic [MAG_W-1:0] mag_to_onehot(input logic [2:0] m);
        logic [MAG_W-1:0] sel;
        case (m)
            3'd1:    sel = 5'b00001;
            3'd2:    sel = 5'b00010;
            3'd3:    sel = 5'b00100;
            3'd4:    sel = 5'b01000;
            3'd5:    sel = 5'b10000;
            default: sel = 5'b00000;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/sd10_digit_cell.sv
module sd10_digit_cell
    import sd10_pkg::*;
(
    input  bcd_digit_t y,
    input  logic       xfer_in,
    output sd_code_t   code
);

    logic       high;
    logic [3:0] mag_wide;

    always_comb begin
        high = digit_is_high(y);
        if (high)
            mag_wide = 4'd10 - y - {3'b000, xfer_in};
        else
            mag_wide = y + {3'b000, xfer_in};
        code.neg     = high;
        code.mag_sel = mag_to_onehot(mag_wide[2:0]);
    end

endmodule

// File: rtl/sd10_top_cell.sv
module sd10_top_cell
    import sd10_pkg::*;
(
    input  logic     xfer_in,
    output sd_code_t code
);

    always_comb begin
        code.neg     = 1'b0;
        code.mag_sel = mag_to_onehot({2'b00, xfer_in});
    end

endmodule

// File: rtl/sd10_code_reg.sv
module sd10_code_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= d;
    end

endmodule

// File: rtl/sd10_recoder.sv
module sd10_recoder
    import sd10_pkg::*;
#(
    parameter int DIGITS = 16,
    localparam int IN_W  = DIGIT_W * DIGITS,
    localparam int OUT_W = CODE_W * (DIGITS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IN_W-1:0]  bcd_in,
    output logic [OUT_W-1:0] sel_out
);

    logic [DIGITS:0] xfer;
    sd_code_t        codes [DIGITS+1];
    logic [OUT_W-1:0] next_codes;

    assign xfer[0] = 1'b0;

    for (genvar i = 0; i < DIGITS; i++) begin : g_pos
        bcd_digit_t digit;
        assign digit     = bcd_in[DIGIT_W*i +: DIGIT_W];
        assign xfer[i+1] = digit_is_high(digit);

        sd10_digit_cell u_cell (
            .y       (digit),
            .xfer_in (xfer[i]),
            .code    (codes[i])
        );
    end

    sd10_top_cell u_top (
        .xfer_in (xfer[DIGITS]),
        .code    (codes[DIGITS])
    );

    for (genvar j = 0; j <= DIGITS; j++) begin : g_pack
        assign next_codes[CODE_W*j +: CODE_W] = codes[j];
    end

    sd10_code_reg #(.W(OUT_W)) u_reg (
        .clk (clk),
        .rst (rst),
        .d   (next_codes),
        .q   (sel_out)
    );

endmodule

// File: rtl/sd10_recoder_chk.sv
module sd10_recoder_chk #(
    parameter int DIGITS = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic [4*DIGITS-1:0]     bcd_in,
    input logic [6*(DIGITS+1)-1:0] sel_out
);

    // R1: reset empties the output register
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (sel_out == '0));

    // R5: a zero in the lowest digit recodes to a zero code
    a_r5_low_zero: assert property (@(posedge clk) disable iff (rst)
        (bcd_in[3:0] == 4'd0) |=> (sel_out[5:0] == 6'd0));

    // R9: extra top position is never negative and never above one
    a_r9_top_positive: assert property (@(posedge clk) disable iff (rst)
        (!sel_out[6*DIGITS+5]) && (sel_out[6*DIGITS+1 +: 4] == 4'd0));

    for (genvar i = 0; i < DIGITS; i++) begin : g_chk
        // R3: never more than one magnitude line
        a_r3_onehot_mag: assert property (@(posedge clk) disable iff (rst)
            $onehot0(sel_out[6*i +: 5]));

        // Input legality taken for granted (supports R4..R8)
        a_r4_input_is_bcd: assert property (@(posedge clk) disable iff (rst)
            (bcd_in[4*i +: 4] <= 4'd9));

        if (i > 0) begin : g_nine
            // R8: a nine meeting a transfer gives signed zero
            a_r8_nine_with_xfer: assert property (@(posedge clk) disable iff (rst)
                ((bcd_in[4*i +: 4] == 4'd9) && (bcd_in[4*(i-1) +: 4] >= 4'd5))
                |=> (sel_out[6*i +: 6] == 6'b100000));
        end
    end

endmodule

bind sd10_recoder sd10_recoder_chk #(.DIGITS(DIGITS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .bcd_in  (bcd_in),
    .sel_out (sel_out)
);

// File: tb/sd10_recoder_tb.sv
module sd10_recoder_tb;

    localparam int D     = 16;
    localparam int IN_W  = 4 * D;
    localparam int OUT_W = 6 * (D + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [IN_W-1:0]  bcd_in = '0;
    logic [OUT_W-1:0] sel_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    sd10_recoder #(.DIGITS(D)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .bcd_in  (bcd_in),
        .sel_out (sel_out)
    );

    function automatic longint bcd_value(input logic [IN_W-1:0] v);
        longint acc = 0;
        for (int i = D - 1; i >= 0; i--) acc = acc * 10 + longint'(v[4*i +: 4]);
        return acc;
    endfunction

    function automatic logic [5:0] expect_code(input int y, input int t, input bit top);
        int e;
        int m;
        logic [5:0] c;
        if (top) begin
            e = t;
        end else begin
            e = (y >= 5) ? (y + t - 10) : (y + t);
        end
        m = (e < 0) ? -e : e;
        c = '0;
        if (m > 0) c[m-1] = 1'b1;
        c[5] = (!top) && (y >= 5);
        return c;
    endfunction

    function automatic longint decode_sum(input logic [OUT_W-1:0] s);
        longint acc = 0;
        for (int i = D; i >= 0; i--) begin
            int m = 0;
            for (int k = 0; k < 5; k++) if (s[6*i + k]) m = k + 1;
            acc = acc * 10 + (s[6*i + 5] ? -longint'(m) : longint'(m));
        end
        return acc;
    endfunction

    task automatic check_vec(input logic [IN_W-1:0] v);
        logic [OUT_W-1:0] held;
        held = sel_out;
        @(negedge clk);
        bcd_in = v;
        #1;
        n_tests++;
        if (sel_out !== held) begin
            n_fail++;
            $display("FAIL R2 output moved between edges: got %h exp %h", sel_out, held);
        end
        @(negedge clk);
        for (int i = 0; i <= D; i++) begin
            int y;
            int t;
            logic [5:0] exp_c;
            y = (i < D) ? int'(v[4*i +: 4]) : 0;
            t = (i == 0) ? 0 : ((int'(v[4*(i-1) +: 4]) >= 5) ? 1 : 0);
            exp_c = expect_code(y, t, i == D);
            n_tests++;
            if (sel_out[6*i +: 6] !== exp_c) begin
                n_fail++;
                if (i == D)
                    $display("FAIL R9 pos %0d: got %b exp %b", i, sel_out[6*i +: 6], exp_c);
                else if (y < 5 && t == 0)
                    $display("FAIL R5 pos %0d: got %b exp %b", i, sel_out[6*i +: 6], exp_c);
                else if (y < 5)
                    $display("FAIL R6/R4 pos %0d: got %b exp %b", i, sel_out[6*i +: 6], exp_c);
                else if (t == 0)
                    $display("FAIL R7/R3 pos %0d: got %b exp %b", i, sel_out[6*i +: 6], exp_c);
                else
                    $display("FAIL R8 pos %0d: got %b exp %b", i, sel_out[6*i +: 6], exp_c);
            end
        end
        n_tests++;
        if (decode_sum(sel_out) != bcd_value(v)) begin
            n_fail++;
            $display("FAIL R10 weighted sum: got %0d exp %0d", decode_sum(sel_out), bcd_value(v));
        end
    endtask

    function automatic logic [IN_W-1:0] fill(input int y);
        logic [IN_W-1:0] v;
        for (int i = 0; i < D; i++) v[4*i +: 4] = 4'(y);
        return v;
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bcd_in = fill(9);
        repeat (3) @(negedge clk);
        n_tests++;
        if (sel_out !== '0) begin
            n_fail++;
            $display("FAIL R1 reset state: got %h exp 0", sel_out);
        end
        @(negedge clk);
        rst = 1'b0;
        bcd_in = '0;
        @(negedge clk);

        check_vec(fill(0));
        check_vec(fill(4));
        check_vec(fill(5));
        check_vec(fill(9));
        // single non-zero digit at every position
        for (int p = 0; p < D; p++)
            for (int y = 0; y < 10; y++) begin
                logic [IN_W-1:0] v = '0;
                v[4*p +: 4] = 4'(y);
                check_vec(v);
            end
        // every value pair on every adjacent pair of positions
        for (int p = 0; p < D - 1; p++)
            for (int a = 0; a < 10; a++)
                for (int b = 0; b < 10; b++) begin
                    logic [IN_W-1:0] v = '0;
                    v[4*p +: 4]     = 4'(a);
                    v[4*(p+1) +: 4] = 4'(b);
                    check_vec(v);
                end
        // random digit strings
        for (int r = 0; r < 1000; r++) begin
            logic [IN_W-1:0] v;
            for (int i = 0; i < D; i++) v[4*i +: 4] = 4'($urandom_range(9, 0));
            check_vec(v);
        end
        // reset mid-stream clears a loaded register
        check_vec(fill(7));
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        n_tests++;
        if (sel_out !== '0) begin
            n_fail++;
            $display("FAIL R1 reset after load: got %h exp 0", sel_out);
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule